// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines into one master interrupt line for a processor. Each line has an enable bit in a mask. Software can also raise any line by writing a software-request register. When the controller is enabled and idle, it takes the lowest-numbered request that is both pending and enabled. It copies that line's word from an internal 32-entry vector table into a read-only vector register, and it asserts the master line.

The processor reads the vector register to find the handler. It then writes any value to the end-of-interrupt register. The controller then drops the line, clears the software request of the served line, and takes the next pending request. An optional edge-emulation mode holds the master line inactive for a programmable number of clock cycles after each end-of-interrupt write. This serves downstream interrupt inputs that detect only edges.

Registers and the vector table sit behind a single-word Wishbone classic slave. A request is `cyc` and `stb` together. The block answers one cycle later with a one-cycle `ack`. All accesses are full 32-bit words. There is no back-pressure, because every access completes in exactly one cycle.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, the control, mask, software-request and vector registers read 0. No interrupt is in service. `irq_o` is 1, which is the inactive level for the reset polarity.
- R2: The raw-level register (byte offset 0x04) reads the current level of `irq_lines` in bits [N_LINES-1:0]. Its other bits read 0.
- R3: Writing 1s to the set-enable register (0x08) sets the matching mask bits. Writing 1s to the clear-enable register (0x0C) clears them. Bits written as 0 leave the mask unchanged. The mask is read at 0x10.
- R4: When idle and enabled, the controller takes the lowest-index line that is pending and enabled. Pending means the input level OR the software-request bit. The vector register (0x14) then reads vector-table word N for the winning line N.
- R5: While an interrupt is in service, the vector register and the master line hold until an end-of-interrupt write. This is true even if a higher-priority request arrives.
- R6: Any write to the end-of-interrupt register (0x1C) ends service. The next pending enabled request is then taken, with the master line inactive for one cycle between the two. If no request is pending, the line stays inactive.
- R7: Writing 1s to the software-request register (0x18) sets request bits. 0s have no effect. The register reads back its bits. A bit is cleared when its own line's interrupt is acknowledged. Software requests are masked like hardware ones.
- R8: The control register (0x00) holds enable in bit 0, polarity in bit 1 (1 = active-high, 0 = active-low), edge emulation in bit 2, and the pulse length L in bits [31:16]. When enable is 0, the master line is at its inactive level and no interrupt is taken.
- R9: With edge emulation on, the master line is inactive for max(L,1) cycles after the end-of-interrupt write. After that it returns if a request is pending.
- R10: Vector-table word i is at byte offset 0x80+4*i (i = 0..31). It is readable and writable. After reset it holds INIT_BASE + i*INIT_STRIDE.
- R11: `wb_ack` is a single-cycle pulse one cycle after a request. The following always acknowledge: offsets 0x20..0x7C, misaligned addresses, and reads of the write-only registers (0x08, 0x0C, 0x1C). These read 0. Writes to read-only registers have no effect.
- R12: A pending line whose mask bit is 0 never raises the master line and never wins priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_adr | input | ADDR_W | Byte address |
| wb_wdata | input | 32 | Write data |
| wb_rdata | output | 32 | Read data, valid with wb_ack |
| wb_ack | output | 1 | Access acknowledge, one-cycle pulse |
| irq_lines | input | N_LINES | Level-sensitive request lines, line 0 highest priority |
| irq_o | output | 1 | Master interrupt line, polarity per control bit 1 |

## Verification
An end-of-interrupt write and a change in the request set can land on the same clock edge. The sequencer must then finish the old service before it judges the new priority. The bench provokes this by serving a low-priority line and raising a higher-priority line just before the acknowledge write. It then checks that the vector register names the newly raised line rather than the one still waiting. A second collision is between priority selection and masking: a pending line is disabled, and a lower-priority line must win instead.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int DATA_W     = 32;
  localparam int TBL_WORDS  = 32;
  localparam int PULSE_W    = 16;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_RAW  = 3'd1,
    SEL_SETE = 3'd2,
    SEL_CLRE = 3'd3,
    SEL_MASK = 3'd4,
    SEL_VEC  = 3'd5,
    SEL_SWR  = 3'd6,
    SEL_EOI  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [PULSE_W-1:0] pulse_len;
    logic [12:0]        rsvd;
    logic               emu;
    logic               pol;
    logic               en;
  } ctrl_t;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'hFFFF_0007;
endpackage

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R4: the chosen line is pending and no lower index is pending
  always_comb begin
    if (any) begin
      a_r4_lowest_wins: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/irqv_vec_table.sv
module irqv_vec_table #(
  parameter int          WORDS       = 32,
  parameter int          AW          = 5,
  parameter int          DW          = 32,
  parameter logic [DW-1:0] INIT_BASE   = '0,
  parameter logic [DW-1:0] INIT_STRIDE = DW'(4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] bus_idx,
  output logic [DW-1:0] bus_data,
  input  logic [AW-1:0] win_idx,
  output logic [DW-1:0] win_data
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= INIT_BASE + INIT_STRIDE * DW'(i);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign bus_data = mem[bus_idx];
  assign win_data = mem[win_idx];
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq #(
  parameter int IW = 5,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          emu,
  input  logic [LW-1:0] pulse_len,
  input  logic          any,
  input  logic [IW-1:0] win_idx,
  input  logic [DW-1:0] win_vec,
  input  logic          eoi,
  output logic [IW-1:0] cur_idx,
  output logic [DW-1:0] vec_q,
  output logic          ack_done,
  output logic          line_active
);
  logic          in_service;
  logic [LW-1:0] gap_cnt;
  logic          take;

  assign take        = en && !in_service && any && !eoi;
  assign ack_done    = eoi && in_service;
  assign line_active = en && in_service && (gap_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_service <= 1'b0;
      cur_idx    <= '0;
      vec_q      <= '0;
      gap_cnt    <= '0;
    end else if (eoi) begin
      in_service <= 1'b0;
      if (emu) gap_cnt <= pulse_len;
    end else begin
      if (take) begin
        in_service <= 1'b1;
        cur_idx    <= win_idx;
        vec_q      <= win_vec;
      end
      if (gap_cnt != '0) gap_cnt <= gap_cnt - LW'(1);
    end
  end

  // R5: service state and vector hold until acknowledged
  a_r5_hold_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    in_service && !eoi |=> in_service && $stable(vec_q) && $stable(cur_idx));

  // R8: nothing is taken while the controller is disabled
  a_r8_no_take_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !in_service |=> !in_service);

  // R6: an acknowledge always ends the current service
  a_r6_eoi_releases: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !line_active);
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int                N_LINES     = 32,
  parameter int                ADDR_W      = 8,
  parameter logic [DATA_W-1:0] INIT_BASE   = '0,
  parameter logic [DATA_W-1:0] INIT_STRIDE = 32'h4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wb_cyc,
  input  logic               wb_stb,
  input  logic               wb_we,
  input  logic [ADDR_W-1:0]  wb_adr,
  input  logic [DATA_W-1:0]  wb_wdata,
  output logic [DATA_W-1:0]  wb_rdata,
  output logic               wb_ack,
  input  logic [N_LINES-1:0] irq_lines,
  output logic               irq_o
);
  localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam int TW = $clog2(TBL_WORDS);

  ctrl_t              ctrl_q;
  logic [N_LINES-1:0] mask_q, swr_q, pending, clr_vec;
  logic               access, wr, is_reg, is_tbl, eoi;
  reg_sel_e           sel;
  logic [TW-1:0]      tbl_idx;
  logic [DATA_W-1:0]  tbl_bus_data, win_vec, vec_q, rd_mux;
  logic               any, ack_done, line_active;
  logic [IW-1:0]      win_idx, cur_idx;

  assign access  = wb_cyc && wb_stb && !wb_ack;
  assign wr      = access && wb_we;
  assign is_reg  = ((wb_adr >> 5) == '0) && (wb_adr[1:0] == 2'b00);
  assign is_tbl  = ((wb_adr >> 7) == ADDR_W'(1)) && (wb_adr[1:0] == 2'b00);
  assign sel     = reg_sel_e'(wb_adr[4:2]);
  assign tbl_idx = wb_adr[6:2];
  assign eoi     = wr && is_reg && (sel == SEL_EOI);
  assign pending = (irq_lines | swr_q) & mask_q;
  assign clr_vec = ack_done ? (N_LINES'(1) << cur_idx) : '0;

  irqv_prio_pick #(.N(N_LINES), .IW(IW)) u_pick (
    .req(pending), .any(any), .idx(win_idx));

  irqv_vec_table #(.WORDS(TBL_WORDS), .AW(TW), .DW(DATA_W),
                   .INIT_BASE(INIT_BASE), .INIT_STRIDE(INIT_STRIDE)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr && is_tbl), .wr_idx(tbl_idx), .wr_data(wb_wdata),
    .bus_idx(tbl_idx), .bus_data(tbl_bus_data),
    .win_idx(TW'(win_idx)), .win_data(win_vec));

  irqv_seq #(.IW(IW), .DW(DATA_W), .LW(PULSE_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl_q.en), .emu(ctrl_q.emu), .pulse_len(ctrl_q.pulse_len),
    .any(any), .win_idx(win_idx), .win_vec(win_vec), .eoi(eoi),
    .cur_idx(cur_idx), .vec_q(vec_q), .ack_done(ack_done),
    .line_active(line_active));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      swr_q  <= '0;
    end else begin
      swr_q <= swr_q & ~clr_vec;
      if (wr && is_reg) begin
        case (sel)
          SEL_CTRL: ctrl_q <= ctrl_t'(wb_wdata & CTRL_WMASK);
          SEL_SETE: mask_q <= mask_q | wb_wdata[N_LINES-1:0];
          SEL_CLRE: mask_q <= mask_q & ~wb_wdata[N_LINES-1:0];
          SEL_SWR:  swr_q  <= (swr_q & ~clr_vec) | wb_wdata[N_LINES-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (is_tbl) rd_mux = tbl_bus_data;
    else if (is_reg) begin
      case (sel)
        SEL_CTRL: rd_mux = ctrl_q;
        SEL_RAW:  rd_mux = DATA_W'(irq_lines);
        SEL_MASK: rd_mux = DATA_W'(mask_q);
        SEL_VEC:  rd_mux = vec_q;
        SEL_SWR:  rd_mux = DATA_W'(swr_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_ack   <= 1'b0;
      wb_rdata <= '0;
    end else begin
      wb_ack <= access;
      if (access) wb_rdata <= wb_we ? '0 : rd_mux;
    end
  end

  assign irq_o = ctrl_q.pol ? line_active : !line_active;

  // R11: acknowledge never lasts more than one cycle
  a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack |=> !wb_ack);

  // R7: the served line's software request is gone after its acknowledge
  a_r7_swr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done |=> !swr_q[$past(cur_idx)]);
endmodule

// File: tb/irqv_ctrl_bench.sv
module irqv_ctrl_bench;
  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 0, stb = 0, we = 0;
  logic [7:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic        ack;
  logic [NL-1:0] lines = '0;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irqv_ctrl #(.N_LINES(NL), .ADDR_W(8), .INIT_BASE(32'h1000), .INIT_STRIDE(32'h10)) u_irqv_ctrl (
    .clk(clk), .rst_n(rst_n), .wb_cyc(cyc), .wb_stb(stb), .wb_we(we),
    .wb_adr(adr), .wb_wdata(wdat), .wb_rdata(rdat), .wb_ack(ack),
    .irq_lines(lines), .irq_o(irq));

  function automatic logic [31:0] tblv(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'd3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    @(negedge clk); cyc = 0; stb = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk); d = rdat; cyc = 0; stb = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gap_after_eoi(output int n);
    n = 0;
    while (irq == 1'b0 && n < 100) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int g;
    idle(3); rst_n = 1; idle(1);

    // R1 reset state
    chk("R1 irq_o", 32'(irq), 32'd1);
    bus_rd(8'h00, d); chk("R1 ctrl", d, 0);
    bus_rd(8'h10, d); chk("R1 mask", d, 0);
    bus_rd(8'h18, d); chk("R1 swr", d, 0);
    bus_rd(8'h14, d); chk("R1 vec", d, 0);

    // R10 reset table contents, then full write/read
    bus_rd(8'h80, d); chk("R10 init0", d, 32'h1000);
    bus_rd(8'h94, d); chk("R10 init5", d, 32'h1050);
    bus_rd(8'hFC, d); chk("R10 init31", d, 32'h11F0);
    for (int i = 0; i < 32; i++) bus_wr(8'(8'h80 + 4 * i), tblv(i));
    for (int i = 0; i < 32; i++) begin
      bus_rd(8'(8'h80 + 4 * i), d); chk("R10 table", d, tblv(i));
    end

    // R11 ack timing, unmapped, misaligned, write-only, read-only write ignored
    @(negedge clk); cyc = 1; stb = 1; we = 0; adr = 8'h04;
    chk("R11 no early ack", 32'(ack), 0);
    @(negedge clk); chk("R11 ack", 32'(ack), 1); cyc = 0; stb = 0;
    @(negedge clk); chk("R11 ack drops", 32'(ack), 0);
    bus_rd(8'h20, d); chk("R11 unmapped 0x20", d, 0);
    bus_rd(8'h7C, d); chk("R11 unmapped 0x7C", d, 0);
    bus_rd(8'h82, d); chk("R11 misaligned", d, 0);
    bus_rd(8'h08, d); chk("R11 set-enable reads 0", d, 0);
    bus_rd(8'h1C, d); chk("R11 eoi reads 0", d, 0);
    bus_wr(8'h10, 32'hFF); bus_rd(8'h10, d); chk("R11 mask read-only", d, 0);
    bus_wr(8'h14, 32'h55); bus_rd(8'h14, d); chk("R11 vec read-only", d, 0);

    // R2 raw level sweep
    for (int p = 0; p < 256; p++) begin
      lines = 8'(p);
      bus_rd(8'h04, d); chk("R2 raw", d, 32'(p));
    end
    lines = '0;

    // R3 set/clear enable
    bus_wr(8'h08, 32'h0F); bus_rd(8'h10, d); chk("R3 set", d, 32'h0F);
    bus_wr(8'h08, 32'h00); bus_rd(8'h10, d); chk("R3 set zero", d, 32'h0F);
    bus_wr(8'h0C, 32'h05); bus_rd(8'h10, d); chk("R3 clear", d, 32'h0A);
    bus_wr(8'h0C, 32'h00); bus_rd(8'h10, d); chk("R3 clear zero", d, 32'h0A);
    bus_wr(8'h08, 32'hFF); bus_rd(8'h10, d); chk("R3 set all", d, 32'hFF);

    // R8 enable gate and polarity (bit0 en, bit1 pol)
    lines = 8'h01; bus_wr(8'h00, 32'h0); idle(4);
    chk("R8 disabled inactive", 32'(irq), 1);
    bus_rd(8'h14, d); chk("R8 disabled no take", d, 0);
    bus_wr(8'h00, 32'h0001); idle(3);
    chk("R8 active-low asserted", 32'(irq), 0);
    bus_rd(8'h00, d); chk("R8 ctrl readback", d, 32'h0001);
    bus_rd(8'h14, d); chk("R4 vec line0", d, tblv(0));
    lines = '0; bus_wr(8'h1C, 0); idle(2);
    chk("R6 released active-low", 32'(irq), 1);
    bus_wr(8'h00, 32'h0003); idle(2);
    chk("R8 active-high idle", 32'(irq), 0);

    // R4 priority sweep over all nonzero patterns
    for (int p = 1; p < 256; p++) begin
      int w;
      w = 0;
      while (((p >> w) & 1) == 0) w++;
      lines = 8'(p); idle(3);
      chk("R4 asserted", 32'(irq), 1);
      bus_rd(8'h14, d); chk("R4 vector", d, tblv(w));
      lines = '0; bus_wr(8'h1C, 32'hDEAD); idle(2);
      chk("R6 released", 32'(irq), 0);
    end

    // R12 masked line ignored
    bus_wr(8'h0C, 32'h01); lines = 8'h01; idle(4);
    chk("R12 masked quiet", 32'(irq), 0);
    lines = 8'h03; idle(3);
    bus_rd(8'h14, d); chk("R12 next line wins", d, tblv(1));
    lines = '0; bus_wr(8'h1C, 0); bus_wr(8'h08, 32'h01); idle(2);

    // R5 hold while in service; collision of EOI with new request
    lines = 8'h80; idle(3);
    bus_rd(8'h14, d); chk("R5 serving 7", d, tblv(7));
    lines = 8'h81; idle(3);
    bus_rd(8'h14, d); chk("R5 vector held", d, tblv(7));
    chk("R5 line held", 32'(irq), 1);
    lines = 8'h84;
    bus_wr(8'h1C, 0); idle(2);
    bus_rd(8'h14, d); chk("R6 collision picks 2", d, tblv(2));
    lines = '0; bus_wr(8'h1C, 0); idle(2);

    // R6 / R9 back-to-back service gap without emulation
    lines = 8'h06; idle(3);
    bus_rd(8'h14, d); chk("R6 serving 1", d, tblv(1));
    lines = 8'h04;
    bus_wr(8'h1C, 0); gap_after_eoi(g);
    chk("R9 gap no emulation", 32'(g), 1);
    bus_rd(8'h14, d); chk("R6 next served", d, tblv(2));
    lines = '0; bus_wr(8'h1C, 0); idle(4);
    chk("R6 stays released", 32'(irq), 0);

    // R7 software requests
    bus_wr(8'h18, 32'h10); bus_rd(8'h18, d); chk("R7 swr set", d, 32'h10);
    idle(2); chk("R7 swr raises", 32'(irq), 1);
    bus_rd(8'h14, d); chk("R7 swr vector", d, tblv(4));
    bus_wr(8'h18, 32'h00); bus_rd(8'h18, d); chk("R7 zero no effect", d, 32'h10);
    bus_wr(8'h1C, 0); bus_rd(8'h18, d); chk("R7 cleared on ack", d, 0);
    idle(2); chk("R7 released", 32'(irq), 0);
    bus_wr(8'h0C, 32'h20); bus_wr(8'h18, 32'h20); idle(3);
    chk("R7 masked swr quiet", 32'(irq), 0);
    bus_rd(8'h18, d); chk("R7 masked swr kept", d, 32'h20);
    bus_wr(8'h08, 32'h20); idle(3);
    bus_rd(8'h14, d); chk("R7 unmasked swr taken", d, tblv(5));
    bus_wr(8'h1C, 0); bus_rd(8'h18, d); chk("R7 swr5 cleared", d, 0);

    // R9 edge emulation pulse lengths (bit2 emu, [31:16] length)
    for (int k = 0; k < 4; k++) begin
      int len;
      int ex;
      len = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 7;
      ex = (len < 1) ? 1 : len;
      bus_wr(8'h00, (32'(len) << 16) | 32'h7);
      lines = 8'h08; idle(3);
      chk("R9 asserted", 32'(irq), 1);
      bus_wr(8'h1C, 0); gap_after_eoi(g);
      chk("R9 emulated gap", 32'(g), 32'(ex));
      lines = '0; bus_wr(8'h1C, 0); idle(2);
    end
    idle(20);
    chk("R9 quiet after emulation", 32'(irq), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule